// File: doc/BRIEF.md
# Topology-Aware Prefetch Issue-Time Predictor

This block sits in a memory expander that is reached through a tree of switches. Each demand arrival is logged with a cycle timestamp. An arrival is either a real read that reaches the device or a notice, relayed from the host, that a read was served from a host-side cache. From a circular history of recent arrival times the block predicts when the next demand will come. The prediction is the newest arrival plus the mean spacing between the arrivals held in the history.

The predicted time is moved earlier by the end-to-end latency between host and device. The data fetched in response then reaches the host buffer just before the demand does. That latency is loaded through a strobe from three configuration values: the number of switch levels on the path, a delay per switch level, and the device's own access latency. When the free-running time counter reaches the computed issue time, the block gives a single-cycle fire pulse. If that time has already passed when the prediction is ready, the pulse comes at once. Choosing the address and moving the data are handled elsewhere.

Top module: `pf_timing_pred`

## Requirements
- R1: After reset `now_o` is 0. It then advances by one every cycle and wraps from 2^TS_W-1 to 0.
- R2: A pulse on `arr_read_i` and a pulse on `arr_hit_i` are logged the same way, with the current `now_o` as the timestamp. Both strobes high in one cycle log a single arrival.
- R3: Reset clears `pred_valid_o`, `fire_o` and `e2e_lat_o`. While fewer than two arrivals are held, no prediction is produced and `pred_valid_o` stays low.
- R4: The history holds the last HIST_DEPTH timestamps (20 by default) and overwrites the oldest when full. With N entries held, N ≥ 2, `pred_next_o` = newest + floor((newest − oldest) / (N − 1)).
- R5: When `lat_load_i` is high, `e2e_lat_o` takes `sw_depth_i`·`hop_delay_i` + `dev_lat_i` on the next cycle. Without the strobe it keeps its value, whatever the configuration inputs do.
- R6: `issue_time_o` = `pred_next_o` − `e2e_lat_o`. `fire_o` is a one-cycle pulse in the cycle whose `now_o` equals `issue_time_o` + 1, so it is registered on the edge that ends the cycle where `now_o` = `issue_time_o`.
- R7: If `issue_time_o` is at or before `now_o` in the first cycle that `pred_valid_o` is high, `fire_o` pulses in the next cycle.
- R8: Every arrival drops `pred_valid_o` on the next cycle and cancels any pending fire. `pred_valid_o` rises again TS_W+3 cycles after the edge that logged the arrival, and is still low one cycle earlier.
- R9: All time arithmetic is modulo 2^TS_W. Spans and issue times that cross a wrap of the counter give the same results as spans and issue times that do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arr_read_i | input | 1 | A real read arrived this cycle |
| arr_hit_i | input | 1 | Host relayed a cache-hit notice this cycle |
| lat_load_i | input | 1 | Latch a new end-to-end latency |
| sw_depth_i | input | DEPTH_W | Switch levels between host and device |
| hop_delay_i | input | LAT_W | Delay per switch level, in cycles |
| dev_lat_i | input | LAT_W | Device access latency, in cycles |
| now_o | output | TS_W | Free-running timestamp |
| e2e_lat_o | output | TS_W | Latched end-to-end latency |
| pred_valid_o | output | 1 | Prediction and issue time are valid |
| pred_next_o | output | TS_W | Predicted next arrival time |
| issue_time_o | output | TS_W | Time at which to issue the prefetch |
| fire_o | output | 1 | One-cycle prefetch-issue pulse |

## Verification
Each result is due at a fixed cycle:
- `e2e_lat_o` one cycle after the load strobe.
- `now_o` advances by one every cycle.
- `pred_valid_o` exactly TS_W+3 cycles after the edge that logs an arrival.
- `fire_o` in the cycle whose `now_o` is one past either the issue time or the first valid cycle, whichever is later.

The bench drives inputs and samples outputs on the falling edge. It waits that exact number of falling edges before it checks, and it confirms that `pred_valid_o` is still low one cycle earlier. The timestamp it records for an arrival is `now_o` in the cycle the strobe is driven. The fire time is found by polling, and the bench then compares the `now_o` of the fire cycle against its own expected value.

// File: rtl/pftp_pkg.sv
package pftp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_LOAD,
    ST_DIV
  } calc_st_e;
endpackage

// File: rtl/pftp_e2e_lat.sv
module pftp_e2e_lat #(
  parameter int TS_W    = 32,
  parameter int DEPTH_W = 4,
  parameter int LAT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [DEPTH_W-1:0] depth,
  input  logic [LAT_W-1:0]   hop,
  input  logic [LAT_W-1:0]   dev,
  output logic [TS_W-1:0]    e2e
);
  logic [TS_W-1:0] path_lat;

  // Path term grows linearly with the number of switch levels.
  always_comb path_lat = TS_W'(depth) * TS_W'(hop);

  always_ff @(posedge clk) begin
    if (rst)       e2e <= '0;
    else if (load) e2e <= path_lat + TS_W'(dev);
  end
endmodule

// File: rtl/pftp_history.sv
module pftp_history #(
  parameter int TS_W  = 32,
  parameter int DEPTH = 20,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [TS_W-1:0]  stamp,
  output logic [CNT_W-1:0] count,
  output logic [TS_W-1:0]  newest,
  output logic [TS_W-1:0]  oldest
);
  logic [TS_W-1:0]  mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic             full;

  always_comb begin
    full   = (count == CNT_W'(DEPTH));
    // Before the ring fills, the first slot written is the oldest.
    rd_ptr = full ? wr_ptr : '0;
  end

  // Plain write port, no reset: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= stamp;
  end

  // Registered read port keeps the RAM inference intact.
  always_ff @(posedge clk) begin
    oldest <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      count  <= '0;
      newest <= '0;
    end else if (push) begin
      newest <= stamp;
      wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      if (!full) count <= count + CNT_W'(1);
    end
  end
endmodule

// File: rtl/pftp_divider.sv
module pftp_divider #(
  parameter int N_W = 32,
  parameter int D_W = 5,
  localparam int STEP_W = $clog2(N_W + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [N_W-1:0]  dividend,
  input  logic [D_W-1:0]  divisor,
  output logic            done,
  output logic [N_W-1:0]  quotient
);
  logic [D_W-1:0]    rem;
  logic [D_W-1:0]    dvs;
  logic [STEP_W-1:0] steps;
  logic              busy;
  logic [D_W:0]      shifted;
  logic [D_W:0]      diff;
  logic              take;

  // One restoring step: bring in the next dividend bit, subtract if it fits.
  always_comb begin
    shifted = {rem, quotient[N_W-1]};
    diff    = shifted - {1'b0, dvs};
    take    = (shifted >= {1'b0, dvs});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem      <= '0;
      dvs      <= '0;
      steps    <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      quotient <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem      <= '0;
        dvs      <= divisor;
        quotient <= dividend;
        steps    <= STEP_W'(N_W);
        busy     <= 1'b1;
      end else if (busy) begin
        quotient <= {quotient[N_W-2:0], take};
        rem      <= take ? diff[D_W-1:0] : shifted[D_W-1:0];
        steps    <= steps - STEP_W'(1);
        if (steps == STEP_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pf_timing_pred.sv
module pf_timing_pred
  import pftp_pkg::*;
#(
  parameter int TS_W       = 32,
  parameter int HIST_DEPTH = 20,
  parameter int DEPTH_W    = 4,
  parameter int LAT_W      = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               arr_read_i,
  input  logic               arr_hit_i,
  input  logic               lat_load_i,
  input  logic [DEPTH_W-1:0] sw_depth_i,
  input  logic [LAT_W-1:0]   hop_delay_i,
  input  logic [LAT_W-1:0]   dev_lat_i,
  output logic [TS_W-1:0]    now_o,
  output logic [TS_W-1:0]    e2e_lat_o,
  output logic               pred_valid_o,
  output logic [TS_W-1:0]    pred_next_o,
  output logic [TS_W-1:0]    issue_time_o,
  output logic               fire_o
);
  localparam int CNT_W = $clog2(HIST_DEPTH + 1);

  calc_st_e         st;
  logic             arrival;
  logic [CNT_W-1:0] hist_cnt;
  logic [TS_W-1:0]  newest;
  logic [TS_W-1:0]  oldest;
  logic [TS_W-1:0]  span;
  logic [TS_W-1:0]  mean_gap;
  logic [TS_W-1:0]  pred_sum;
  logic [TS_W-1:0]  lead;
  logic [CNT_W-1:0] gaps;
  logic             div_start;
  logic             div_done;
  logic             due;
  logic             armed;

  always_comb begin
    arrival   = arr_read_i | arr_hit_i;
    // Sum of consecutive gaps telescopes to newest - oldest (mod 2^TS_W).
    span      = newest - oldest;
    gaps      = hist_cnt - CNT_W'(1);
    pred_sum  = newest + mean_gap;
    div_start = (st == ST_LOAD);
    // Signed distance past the issue time; sign bit clear means due.
    lead      = now_o - issue_time_o;
    due       = ~lead[TS_W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) now_o <= '0;
    else     now_o <= now_o + TS_W'(1);
  end

  pftp_e2e_lat #(
    .TS_W   (TS_W),
    .DEPTH_W(DEPTH_W),
    .LAT_W  (LAT_W)
  ) u_e2e (
    .clk  (clk),
    .rst  (rst),
    .load (lat_load_i),
    .depth(sw_depth_i),
    .hop  (hop_delay_i),
    .dev  (dev_lat_i),
    .e2e  (e2e_lat_o)
  );

  pftp_history #(
    .TS_W (TS_W),
    .DEPTH(HIST_DEPTH)
  ) u_hist (
    .clk   (clk),
    .rst   (rst),
    .push  (arrival),
    .stamp (now_o),
    .count (hist_cnt),
    .newest(newest),
    .oldest(oldest)
  );

  pftp_divider #(
    .N_W(TS_W),
    .D_W(CNT_W)
  ) u_div (
    .clk     (clk),
    .rst     (rst),
    .start   (div_start),
    .dividend(span),
    .divisor (gaps),
    .done    (div_done),
    .quotient(mean_gap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      armed        <= 1'b0;
      fire_o       <= 1'b0;
      pred_valid_o <= 1'b0;
      pred_next_o  <= '0;
      issue_time_o <= '0;
    end else begin
      fire_o <= 1'b0;
      if (arrival) begin
        // A fresh arrival voids the old estimate and any pending issue.
        pred_valid_o <= 1'b0;
        armed        <= 1'b0;
        st           <= (hist_cnt != '0) ? ST_READ : ST_IDLE;
      end else begin
        unique case (st)
          ST_READ: st <= ST_LOAD;
          ST_LOAD: st <= ST_DIV;
          ST_DIV: begin
            if (div_done) begin
              pred_next_o  <= pred_sum;
              issue_time_o <= pred_sum - e2e_lat_o;
              pred_valid_o <= 1'b1;
              armed        <= 1'b1;
              st           <= ST_IDLE;
            end
          end
          default: begin
            if (armed && due) begin
              fire_o <= 1'b1;
              armed  <= 1'b0;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/pf_timing_pred_chk.sv
module pf_timing_pred_chk #(
  parameter int TS_W    = 32,
  parameter int DEPTH_W = 4,
  parameter int LAT_W   = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               arr_read_i,
  input logic               arr_hit_i,
  input logic               lat_load_i,
  input logic [DEPTH_W-1:0] sw_depth_i,
  input logic [LAT_W-1:0]   hop_delay_i,
  input logic [LAT_W-1:0]   dev_lat_i,
  input logic [TS_W-1:0]    now_o,
  input logic [TS_W-1:0]    e2e_lat_o,
  input logic               pred_valid_o,
  input logic               fire_o
);
  p_now_step_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> now_o == TS_W'($past(now_o) + TS_W'(1)));

  p_lat_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !lat_load_i |=> $stable(e2e_lat_o));

  p_fire_has_pred_r6: assert property (@(posedge clk) disable iff (rst)
    fire_o |-> pred_valid_o);

  p_fire_single_r6: assert property (@(posedge clk) disable iff (rst)
    fire_o |=> !fire_o);

  p_arrival_drops_r8: assert property (@(posedge clk) disable iff (rst)
    (arr_read_i || arr_hit_i) |=> !pred_valid_o && !fire_o);
endmodule

bind pf_timing_pred pf_timing_pred_chk #(
  .TS_W   (TS_W),
  .DEPTH_W(DEPTH_W),
  .LAT_W  (LAT_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .arr_read_i  (arr_read_i),
  .arr_hit_i   (arr_hit_i),
  .lat_load_i  (lat_load_i),
  .sw_depth_i  (sw_depth_i),
  .hop_delay_i (hop_delay_i),
  .dev_lat_i   (dev_lat_i),
  .now_o       (now_o),
  .e2e_lat_o   (e2e_lat_o),
  .pred_valid_o(pred_valid_o),
  .fire_o      (fire_o)
);

// File: tb/pf_timing_pred_bench.sv
`timescale 1ns/1ps
module pf_timing_pred_bench;
  localparam int TW   = 12;
  localparam int HD   = 20;
  localparam int DW   = 4;
  localparam int LW   = 8;
  localparam int LAT  = TW + 3;
  localparam int MASK = (1 << TW) - 1;
  localparam int HALF = 1 << (TW - 1);
  localparam int NV   = 24;
  localparam int GAP  [NV] = '{20, 5, 40, 12, 60, 8, 30, 25, 3, 50, 15, 35,
                               10, 45, 22, 7, 55, 18, 28, 4, 33, 11, 41, 26};
  localparam int KIND [NV] = '{1, 2, 1, 3, 1, 1, 2, 1, 3, 2, 1, 1,
                               2, 1, 1, 3, 1, 2, 1, 1, 2, 1, 3, 1};

  logic          clk = 1'b0;
  logic          rst;
  logic          arr_read_i, arr_hit_i, lat_load_i;
  logic [DW-1:0] sw_depth_i;
  logic [LW-1:0] hop_delay_i, dev_lat_i;
  logic [TW-1:0] now_o, e2e_lat_o, pred_next_o, issue_time_o;
  logic          pred_valid_o, fire_o;

  int checks = 0;
  int fails  = 0;
  int ts_m [HD];
  int cnt_m = 0;
  int wp_m  = 0;
  int e2e_m = 0;

  always #2.5 clk = ~clk;

  pf_timing_pred #(
    .TS_W(TW), .HIST_DEPTH(HD), .DEPTH_W(DW), .LAT_W(LW)
  ) u_pf_timing_pred (
    .clk(clk), .rst(rst), .arr_read_i(arr_read_i), .arr_hit_i(arr_hit_i),
    .lat_load_i(lat_load_i), .sw_depth_i(sw_depth_i), .hop_delay_i(hop_delay_i),
    .dev_lat_i(dev_lat_i), .now_o(now_o), .e2e_lat_o(e2e_lat_o),
    .pred_valid_o(pred_valid_o), .pred_next_o(pred_next_o),
    .issue_time_o(issue_time_o), .fire_o(fire_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Drive one arrival; the timestamp is now_o in the strobe cycle (R2).
  task automatic arrive(input int kind);
    ts_m[wp_m] = int'(now_o);
    wp_m = (wp_m + 1) % HD;
    if (cnt_m < HD) cnt_m++;
    arr_read_i = (kind & 1) != 0;
    arr_hit_i  = (kind & 2) != 0;
    @(negedge clk);
    arr_read_i = 1'b0;
    arr_hit_i  = 1'b0;
  endtask

  function automatic int model_pred();
    int oldest, newest, span;
    oldest = (cnt_m < HD) ? ts_m[0] : ts_m[wp_m];
    newest = ts_m[(wp_m + HD - 1) % HD];
    span   = (newest - oldest) & MASK;
    return (newest + span / (cnt_m - 1)) & MASK;
  endfunction

  // Called right after arrive(): checks R8 timing, R4 value, R6/R7 fire.
  task automatic expect_pred(input string req, output bit late);
    int p, iss, v, expf, got, early;
    early = 0;
    for (int i = 0; i < LAT - 1; i++) begin
      @(negedge clk);
      if (fire_o) early++;
    end
    chk(early == 0, {req, " R8 no stale fire"}, early, 0);
    chk(pred_valid_o == 1'b0, {req, " R8 valid not yet"}, int'(pred_valid_o), 0);
    @(negedge clk);
    p   = model_pred();
    iss = (p - e2e_m) & MASK;
    chk(pred_valid_o == 1'b1, {req, " R8 valid due"}, int'(pred_valid_o), 1);
    chk(int'(pred_next_o) == p, {req, " predicted time"}, int'(pred_next_o), p);
    chk(int'(issue_time_o) == iss, {req, " R6 issue time"}, int'(issue_time_o), iss);
    v    = int'(now_o);
    late = ((v - iss) & MASK) < HALF;
    expf = late ? ((v + 1) & MASK) : ((iss + 1) & MASK);
    got  = -1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (fire_o) begin
        got = int'(now_o);
        break;
      end
    end
    chk(got == expf, {req, " R6 fire cycle"}, got, expf);
    @(negedge clk);
    chk(fire_o == 1'b0, {req, " R6 single pulse"}, int'(fire_o), 0);
  endtask

  task automatic load_lat(input int d, input int h, input int dv);
    lat_load_i  = 1'b1;
    sw_depth_i  = DW'(d);
    hop_delay_i = LW'(h);
    dev_lat_i   = LW'(dv);
    @(negedge clk);
    lat_load_i = 1'b0;
    e2e_m = (d * h + dv) & MASK;
    chk(int'(e2e_lat_o) == e2e_m, "R5 latency latched", int'(e2e_lat_o), e2e_m);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    summary();
  end

  initial begin
    bit late;
    rst = 1'b1;
    arr_read_i = 1'b0; arr_hit_i = 1'b0; lat_load_i = 1'b0;
    sw_depth_i = '0; hop_delay_i = '0; dev_lat_i = '0;
    repeat (3) @(negedge clk);
    chk(pred_valid_o == 1'b0, "R3 reset valid", int'(pred_valid_o), 0);
    chk(fire_o == 1'b0, "R3 reset fire", int'(fire_o), 0);
    chk(e2e_lat_o == '0, "R3 reset latency", int'(e2e_lat_o), 0);
    rst = 1'b0;
    chk(now_o == '0, "R1 reset time", int'(now_o), 0);
    repeat (5) @(negedge clk);
    chk(int'(now_o) == 5, "R1 counting", int'(now_o), 5);

    // R5: 3 levels x 10 + 8, then config changes without strobe are ignored.
    load_lat(3, 10, 8);
    sw_depth_i  = DW'(7);
    hop_delay_i = LW'(99);
    @(negedge clk);
    chk(int'(e2e_lat_o) == 38, "R5 held without strobe", int'(e2e_lat_o), 38);

    // R3: a single arrival yields no prediction.
    arrive(1);
    repeat (LAT + 2) @(negedge clk);
    chk(pred_valid_o == 1'b0, "R3 one arrival no prediction", int'(pred_valid_o), 0);
    chk(fire_o == 1'b0, "R3 one arrival no fire", int'(fire_o), 0);

    // Table walk: reads, host hits and both together; fills and overwrites the ring (R4).
    for (int i = 0; i < NV; i++) begin
      repeat (GAP[i]) @(negedge clk);
      arrive(KIND[i]);
      expect_pred(KIND[i] == 2 ? "R2 hit arrival" :
                  (KIND[i] == 3 ? "R2 both strobes" : "R4 read arrival"), late);
    end

    // R7: latency larger than any mean spacing makes the issue time already past.
    load_lat(5, 100, 200);
    repeat (10) @(negedge clk);
    arrive(1);
    expect_pred("R7 late", late);
    chk(late == 1'b1, "R7 issue already past", int'(late), 1);

    // R8: a new arrival cancels a pending fire and recomputes.
    load_lat(0, 0, 0);
    repeat (300) @(negedge clk);
    arrive(1);
    repeat (LAT) @(negedge clk);
    chk(pred_valid_o == 1'b1, "R8 first estimate ready", int'(pred_valid_o), 1);
    arrive(2);
    chk(pred_valid_o == 1'b0, "R8 estimate dropped", int'(pred_valid_o), 0);
    expect_pred("R8 recompute", late);

    // R1/R9: counter wrap, then an arrival whose span crosses the wrap.
    for (int i = 0; i < 5000; i++) begin
      if (int'(now_o) == MASK) break;
      @(negedge clk);
    end
    chk(int'(now_o) == MASK, "R1 reached top", int'(now_o), MASK);
    @(negedge clk);
    chk(now_o == '0, "R1 wrap to zero", int'(now_o), 0);
    load_lat(2, 7, 3);
    arrive(1);
    expect_pred("R9 across wrap", late);
    repeat (20) @(negedge clk);
    arrive(3);
    expect_pred("R9 after wrap", late);

    summary();
  end
endmodule